// File: doc/BRIEF.md
# Halfword Expansion Memory Bus Controller

This block connects a CPU-side request port to an external 16-bit memory used for program code and expansion data. The CPU issues one request at a time. Each request carries a direction, a size (halfword or 32-bit word), a chip-select index, a halfword-granular address and, for writes, the write data. The block turns each request into one or two 16-bit bus transfers. It drives the address, one of two active-low chip selects, and active-low read and write strobes. It drives the data bus only while writing.

Every transfer lasts at least two bus clocks. The external wait input, active high, is sampled at the end of the second clock. Each clock in which it is sampled high adds one more clock to the transfer. A 32-bit word moves as two transfers. A word read fetches the upper halfword first. A word write stores the lower halfword first. The lower halfword of a word sits at the even halfword address and the upper halfword at the odd address just above it.

The request port is a valid/ready stream. `req_ready` is high only while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. From that edge until the response, `req_ready` stays low, so any request held on the port waits (back-pressure). The response side has no ready: `rsp_valid` pulses for one clock with the result, and the CPU must take it in that clock.

Top module: `prog_bus_if`

## Requirements
- R1: While reset is held and in the first idle clock after it, both chip selects and both strobes are high (inactive), the data bus is not driven, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is accepted only on an edge with `req_valid` and `req_ready` both high. `req_ready` is 0 from the clock after acceptance until the clock in which `rsp_valid` is high, and `req_ready` is 1 again in that clock.
- R3: During a transfer exactly one chip select is low: `mem_cs_n[k]` where k is `req_cs` (`req_cs`=0 pulls bit 0 low). Outside transfers both are high.
- R4: A halfword access (`req_word`=0) makes one transfer at `req_addr`. With no wait, `rsp_valid` is high in the third clock after the accepting edge. A halfword read returns the bus value zero-extended in `rsp_rdata[31:16]`=0.
- R5: A word read makes two transfers, first at the odd address (upper half), then at the even address (lower half), and returns {upper, lower} in `rsp_rdata`.
- R6: A word write makes two transfers. The first writes `req_wdata[15:0]` at the even address; the second writes `req_wdata[31:16]` at the odd address.
- R7: For a word access, bit 0 of `req_addr` is ignored: an odd request address gives the same transfers as the even address below it.
- R8: Each clock in which `mem_wait` is sampled high at the end of the second (or a later) clock of a transfer lengthens that transfer by one clock. Address, chip select and strobe stay steady meanwhile. With no wait, a word access answers in the fifth clock after acceptance.
- R9: `mem_doe` is high only while `mem_wr_n` is low. The read and write strobes are never low together.
- R10: `rsp_valid` is high for exactly one clock per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 32-bit word, 0 = halfword |
| req_cs | input | 1 | Chip-select index |
| req_addr | input | 18 | Halfword address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 32 | Read result (zero for writes) |
| mem_addr | output | 18 | External halfword address |
| mem_cs_n | output | 2 | Chip selects, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_wait | input | 1 | Wait request, active high |
| mem_dout | output | 16 | Data driven to the bus |
| mem_doe | output | 1 | Data bus output enable |
| mem_din | input | 16 | Data read from the bus |

## Verification
The bench goes after the halfword order of word accesses. A design that used one order for both directions would show a swapped address sequence in the transfer scoreboard and a read-back with its halves exchanged. The bench also sends odd addresses with word requests: a design that kept bit 0 would hit the wrong pair of halfwords. Wait stretches of several clocks are applied to both halves of a word. A controller that missed one wait sample, or changed the address mid-stretch, shows a latency different from 5 + 2·N clocks or a corrupted read. It also checks that the data bus is released whenever the write strobe is high and that the completion pulse never lasts two clocks.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_HOLD = 2'd2
  } pbus_state_e;

endpackage

// File: rtl/pbus_ctrl.sv
module pbus_ctrl
  import pbus_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_fire,
  input  logic        word_q,
  input  logic        mem_wait,
  output pbus_state_e state_o,
  output logic        second_o,
  output logic        end_xfer_o,
  output logic        last_xfer_o
);

  pbus_state_e state;
  logic        second;

  assign last_xfer_o = !word_q || second;
  assign end_xfer_o  = (state == ST_HOLD) && !mem_wait;
  assign state_o     = state;
  assign second_o    = second;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      second <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_fire) begin
            state  <= ST_ACT;
            second <= 1'b0;
          end
        end
        ST_ACT:  state <= ST_HOLD;
        ST_HOLD: begin
          if (!mem_wait) begin
            if (last_xfer_o) begin
              state  <= ST_IDLE;
              second <= 1'b0;
            end else begin
              state  <= ST_ACT;
              second <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4/R8: a transfer always spends a clock in the strobe-open phase first
  p_act_leads_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACT) |=> (state == ST_HOLD));

endmodule

// File: rtl/pbus_pins.sv
module pbus_pins
  import pbus_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int NUM_CS = 2,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int WORD_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_fire,
  input  logic              req_write,
  input  logic              req_word,
  input  logic [CS_W-1:0]   req_cs,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  input  pbus_state_e       state,
  input  logic              second,
  input  logic              mem_wait,
  output logic              write_q,
  output logic              word_q,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [NUM_CS-1:0] mem_cs_n,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_doe
);

  logic [ADDR_W-1:0] addr_q;
  logic [CS_W-1:0]   cs_q;
  logic [WORD_W-1:0] wdata_q;
  logic              active;
  logic              upper_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      cs_q    <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      word_q  <= 1'b0;
    end else if (req_fire) begin
      addr_q  <= req_addr;
      cs_q    <= req_cs;
      wdata_q <= req_wdata;
      write_q <= req_write;
      word_q  <= req_word;
    end
  end

  assign active = (state != ST_IDLE);

  // reads fetch the upper half first, writes store the lower half first
  always_comb begin
    if (word_q) upper_sel = write_q ? second : !second;
    else        upper_sel = 1'b0;
  end

  assign mem_addr = word_q ? {addr_q[ADDR_W-1:1], upper_sel} : addr_q;
  assign mem_rd_n = !(active && !write_q);
  assign mem_wr_n = !(active && write_q);
  assign mem_doe  = active && write_q;
  assign mem_dout = upper_sel ? wdata_q[WORD_W-1:DATA_W] : wdata_q[DATA_W-1:0];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign mem_cs_n[g] = !(active && (cs_q == CS_W'(g)));
  end

  p_one_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd_n || !mem_wr_n) |-> ($countones(~mem_cs_n) == 1));
  p_no_cs_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_n && mem_wr_n) |-> (mem_cs_n == '1));
  p_wait_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_HOLD) && mem_wait) |=>
      ($stable(mem_addr) && $stable(mem_cs_n) && $stable(mem_rd_n) && $stable(mem_wr_n)));
  p_oe_in_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_doe |-> !mem_wr_n);
  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_rd_n && !mem_wr_n));

endmodule

// File: rtl/pbus_rdasm.sv
module pbus_rdasm #(
  parameter int DATA_W = 16,
  localparam int WORD_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              end_xfer,
  input  logic              last_xfer,
  input  logic              write_q,
  input  logic              word_q,
  input  logic [DATA_W-1:0] mem_din,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata
);

  logic [DATA_W-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= end_xfer && last_xfer;
      if (end_xfer && !last_xfer && !write_q) hi_q <= mem_din;
      if (end_xfer && last_xfer) begin
        if (write_q)     rsp_rdata <= '0;
        else if (word_q) rsp_rdata <= {hi_q, mem_din};
        else             rsp_rdata <= {{DATA_W{1'b0}}, mem_din};
      end
    end
  end

  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/prog_bus_if.sv
module prog_bus_if
  import pbus_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int NUM_CS = 2,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int WORD_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_word,
  input  logic [CS_W-1:0]   req_cs,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [NUM_CS-1:0] mem_cs_n,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  input  logic              mem_wait,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_doe,
  input  logic [DATA_W-1:0] mem_din
);

  pbus_state_e state;
  logic        second;
  logic        end_xfer;
  logic        last_xfer;
  logic        write_q;
  logic        word_q;
  logic        req_fire;

  assign req_ready = (state == ST_IDLE);
  assign req_fire  = req_valid && req_ready;

  pbus_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_fire    (req_fire),
    .word_q      (word_q),
    .mem_wait    (mem_wait),
    .state_o     (state),
    .second_o    (second),
    .end_xfer_o  (end_xfer),
    .last_xfer_o (last_xfer)
  );

  pbus_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CS(NUM_CS)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_fire  (req_fire),
    .req_write (req_write),
    .req_word  (req_word),
    .req_cs    (req_cs),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .state     (state),
    .second    (second),
    .mem_wait  (mem_wait),
    .write_q   (write_q),
    .word_q    (word_q),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_rd_n  (mem_rd_n),
    .mem_wr_n  (mem_wr_n),
    .mem_dout  (mem_dout),
    .mem_doe   (mem_doe)
  );

  pbus_rdasm #(.DATA_W(DATA_W)) u_rdasm (
    .clk       (clk),
    .rst_n     (rst_n),
    .end_xfer  (end_xfer),
    .last_xfer (last_xfer),
    .write_q   (write_q),
    .word_q    (word_q),
    .mem_din   (mem_din),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  p_ready_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_rd_n && mem_wr_n));
  p_ack_when_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);

endmodule

// File: tb/prog_bus_if_bench.sv
module prog_bus_if_bench;

  localparam int CLK_P = 10;

  typedef struct {
    logic [17:0] a;
    logic [1:0]  csn;
    logic        wr;
    logic [15:0] d;
  } xfer_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_word = 1'b0;
  logic [0:0]  req_cs = 1'b0;
  logic [17:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [17:0] mem_addr;
  logic [1:0]  mem_cs_n;
  logic        mem_rd_n;
  logic        mem_wr_n;
  logic        mem_wait = 1'b0;
  logic [15:0] mem_dout;
  logic        mem_doe;
  logic [15:0] mem_din;

  logic [15:0] bank [2][64];
  xfer_t       exp_q[$];
  int          n_checks = 0;
  int          n_fails = 0;
  int          wait_n = 0;
  int          wait_cnt = 0;
  int          oe_bad = 0;
  logic        prev_act = 1'b0;
  logic [17:0] prev_addr = '0;
  bit          finished = 0;

  always #(CLK_P/2) clk = ~clk;

  prog_bus_if u_prog_bus_if (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_word(req_word), .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .mem_wait(mem_wait), .mem_dout(mem_dout), .mem_doe(mem_doe), .mem_din(mem_din)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // external memory model
  always_comb begin
    mem_din = 16'h0;
    if (!mem_rd_n) mem_din = bank[mem_cs_n[1] == 1'b0 ? 1 : 0][mem_addr[5:0]];
  end

  always @(posedge clk) begin
    if (!mem_wr_n && mem_doe) bank[mem_cs_n[1] == 1'b0 ? 1 : 0][mem_addr[5:0]] <= mem_dout;
  end

  // monitor: transfer scoreboard, wait generator, bus release watch
  always @(negedge clk) begin
    logic act;
    logic is_new;
    act    = !mem_rd_n || !mem_wr_n;
    is_new = act && (!prev_act || mem_addr != prev_addr);
    if (mem_doe && mem_wr_n) oe_bad++;
    if (is_new) begin
      mem_wait <= 1'b0;
      wait_cnt = wait_n;
      if (exp_q.size() == 0) begin
        check(0, "R5/R6 unexpected transfer", {46'h0, mem_addr}, 64'h0);
      end else begin
        xfer_t e;
        e = exp_q.pop_front();
        check(mem_addr == e.a, "R5/R6/R7 transfer address", {46'h0, mem_addr}, {46'h0, e.a});
        check(mem_cs_n == e.csn, "R3 chip select", {62'h0, mem_cs_n}, {62'h0, e.csn});
        check(!mem_wr_n == e.wr, "R6 transfer direction", {63'h0, !mem_wr_n}, {63'h0, e.wr});
        if (e.wr) check(mem_dout == e.d && mem_doe, "R6 write data", {47'h0, mem_doe, mem_dout}, {47'h1, e.d});
      end
    end else if (act) begin
      mem_wait <= (wait_cnt > 0);
      if (wait_cnt > 0) wait_cnt--;
    end else begin
      mem_wait <= 1'b0;
    end
    prev_act  = act;
    prev_addr = mem_addr;
  end

  task automatic push_x(input logic [17:0] a, input logic cs, input logic wr, input logic [15:0] d);
    xfer_t x;
    x.a = a; x.csn = cs ? 2'b01 : 2'b10; x.wr = wr; x.d = d;
    exp_q.push_back(x);
  endtask

  task automatic do_access(input logic wr, input logic wd, input logic cs,
                           input logic [17:0] a, input logic [31:0] wdat,
                           input int nw, input string tag);
    logic [17:0] ev;
    logic [31:0] exp_rd;
    int          cyc;
    int          exp_cyc;
    ev = {a[17:1], 1'b0};
    if (wd) begin
      exp_rd = {bank[cs][ev[5:0] | 6'd1], bank[cs][ev[5:0]]};
      if (wr) begin
        push_x(ev, cs, 1'b1, wdat[15:0]);
        push_x(ev | 18'd1, cs, 1'b1, wdat[31:16]);
      end else begin
        push_x(ev | 18'd1, cs, 1'b0, 16'h0);
        push_x(ev, cs, 1'b0, 16'h0);
      end
      exp_cyc = 5 + 2 * nw;
    end else begin
      exp_rd = {16'h0, bank[cs][a[5:0]]};
      push_x(a, cs, wr, wdat[15:0]);
      exp_cyc = 3 + nw;
    end
    if (wr) exp_rd = 32'h0;
    wait_n = nw;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_word = wd; req_cs = cs;
    req_addr = a; req_wdata = wdat;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    cyc = 0;
    @(negedge clk);
    req_valid = 1'b0;
    cyc++;
    check(!req_ready, {"R2 ready low after accept ", tag}, {63'h0, req_ready}, 64'h0);
    while (!rsp_valid && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc == exp_cyc, {"R4/R8 latency ", tag}, cyc, exp_cyc);
    check(req_ready, {"R2 ready with response ", tag}, {63'h0, req_ready}, 64'h1);
    check(rsp_rdata == exp_rd, {"R4/R5 read result ", tag}, {32'h0, rsp_rdata}, {32'h0, exp_rd});
    @(negedge clk);
    check(!rsp_valid, {"R10 single pulse ", tag}, {63'h0, rsp_valid}, 64'h0);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < 64; i++)
        bank[c][i] = 16'hA000 ^ 16'(c << 8) ^ 16'(i * 16'h0101);
    repeat (3) @(negedge clk);
    // R1: reset values
    check(mem_cs_n == 2'b11 && mem_rd_n && mem_wr_n && !mem_doe, "R1 bus idle in reset",
          {60'h0, mem_cs_n, mem_rd_n, mem_wr_n}, 64'hF);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rsp_valid && mem_cs_n == 2'b11 && !mem_doe, "R1 idle after reset",
          {61'h0, req_ready, rsp_valid, mem_doe}, 64'h4);

    do_access(1'b1, 1'b0, 1'b0, 18'd5, 32'h0000_1234, 0, "R4 half write");
    do_access(1'b0, 1'b0, 1'b0, 18'd5, 32'h0, 0, "R4 half read back");
    check(bank[0][5] == 16'h1234, "R4 half write stored", {48'h0, bank[0][5]}, 64'h1234);
    do_access(1'b0, 1'b1, 1'b1, 18'd8, 32'h0, 0, "R5 word read cs1");
    do_access(1'b1, 1'b1, 1'b0, 18'h11, 32'hDEAD_BEEF, 0, "R6 R7 word write odd addr");
    check(bank[0][16] == 16'hBEEF && bank[0][17] == 16'hDEAD, "R6 word halves stored",
          {32'h0, bank[0][17], bank[0][16]}, 64'hDEADBEEF);
    do_access(1'b0, 1'b1, 1'b0, 18'h11, 32'h0, 0, "R5 R7 word read odd addr");
    do_access(1'b0, 1'b0, 1'b1, 18'd3, 32'h0, 3, "R8 half read wait3");
    do_access(1'b1, 1'b1, 1'b1, 18'd20, 32'h1357_2468, 2, "R8 word write wait2");
    do_access(1'b0, 1'b1, 1'b1, 18'd20, 32'h0, 1, "R8 word read wait1");
    do_access(1'b1, 1'b0, 1'b1, 18'd33, 32'hFFFF_5A5A, 0, "R3 half write cs1");
    check(bank[1][33] == 16'h5A5A && bank[0][33] != 16'h5A5A, "R3 only selected bank written",
          {32'h0, bank[1][33], bank[0][33]}, {48'h0, 16'h5A5A});

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R5/R6 all transfers seen", exp_q.size(), 0);
    check(oe_bad == 0, "R9 bus released outside write strobe", oe_bad, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule